// File: doc/BRIEF.md
# Wakeup Countdown Timer with Interrupt

This block counts down from a software preset at the rate of a slow source tick and raises an event each time the count runs out. Each event sets a sticky status flag. If the interrupt enable is set, the event also asserts a drive-low request for an active-low, open-drain interrupt line. The count begins only when the run bit is written from 0 to 1. It always begins from the preset. While run stays 1 the counter reloads after every event, so events repeat with a fixed period.

Software reaches the block through one write strobe and a one-bit register select. The control register holds three bits: run at bit 0, flag at bit 1 and interrupt enable at bit 2. The preset register holds a CNT_W-bit count. Writing 0 to the flag clears it. Writing 1 to the flag does nothing. Clearing the flag does not drop the interrupt line. The line is released by a write that sets the interrupt enable to 0, or by itself after REL_TICKS periods of a separate fast release tick.

Top module: `wkt_top`

## Requirements
- R1: After reset, run, flag, interrupt enable and preset read back as 0, and `irq_o` is 0.
- R2: While run is 0, the counter holds the preset, source ticks produce no event, and the flag never sets. Writing 1 to the flag bit while stopped does nothing.
- R3: A control write that changes run from 0 to 1 reloads the count from the preset. The first event comes on exactly the max(P,1)-th source tick after that write, where P is the preset. Any partial count left from an earlier run has no effect.
- R4: While run stays 1, the counter reloads after each event, so later events also come every max(P,1) source ticks. A control write with run=1 while already running does not restart the count.
- R5: An event sets the flag (control bit 1), and the flag holds until a control write carries 0 in bit 1. A write carrying 1 in bit 1 leaves the flag unchanged.
- R6: If an event and a flag-clearing write fall in the same cycle, the flag is 1 afterwards.
- R7: `irq_o` rises on the cycle after an event that moves the flag from 0 to 1, but only if the interrupt enable (the value after any write in that same cycle) is 1.
- R8: An event that comes while the flag is already 1, and is not cleared in that cycle, does not assert `irq_o`.
- R9: Clearing the flag leaves an asserted `irq_o` at 1.
- R10: A control write with bit 2 equal to 0 makes `irq_o` 0 on the next cycle.
- R11: An asserted `irq_o` drops after the REL_TICKS-th release tick that follows the assertion edge. A release tick in the same cycle as the asserting event is not counted.
- R12: A preset write while running takes effect at the next reload. Select 0 reads {ie, flag, run} in bits 2..0. Select 1 reads the preset.
- R13: A control write with run=0 stops the count and reloads it, and produces no event, even when a source tick arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Single-cycle register write strobe |
| reg_sel | input | 1 | Register select: 0 control, 1 preset |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data for the selected register (combinational) |
| src_tick | input | 1 | Countdown tick enable |
| rel_tick | input | 1 | Fast tick that times the interrupt release |
| flag_o | output | 1 | Sticky event flag |
| irq_o | output | 1 | Drive-low request for the interrupt line (1 = pull low) |

## Verification
Two pairs of functions can fall in the same cycle. A counter event can meet a flag-clearing write. A counter event can also meet a write that changes the interrupt enable. The bench provokes both by counting the source ticks up to the last tick before expiry, then issuing the control write together with the expiring tick. It expects the flag to stay set and the line to assert when the enable written in that cycle is 1. A release tick coinciding with the asserting event, and a stop write coinciding with the expiring tick, are provoked the same way and judged against the arithmetic period max(P,1).

// File: rtl/wkt_pkg.sv
package wkt_pkg;
    typedef enum logic {
        SEL_CTRL   = 1'b0,
        SEL_PRESET = 1'b1
    } wkt_sel_e;

    localparam int CTRL_RUN  = 0;
    localparam int CTRL_FLAG = 1;
    localparam int CTRL_IE   = 2;
    localparam int CTRL_W    = 3;
endpackage

// File: rtl/wkt_regs.sv
module wkt_regs
    import wkt_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             sel,
    input  logic [CNT_W-1:0] wdata,
    input  logic             flag_i,
    output logic             run_q,
    output logic             run_nx,
    output logic             ie_q,
    output logic             ie_nx,
    output logic             flag_clr,
    output logic [CNT_W-1:0] preset_q,
    output logic [CNT_W-1:0] rdata
);
    typedef struct packed {
        logic             run;
        logic             ie;
        logic [CNT_W-1:0] preset;
    } regs_t;

    regs_t st_d, st_q;
    logic  ctrl_wr;

    always_comb begin
        st_d     = st_q;
        ctrl_wr  = wr && (sel == SEL_CTRL);
        flag_clr = ctrl_wr && !wdata[CTRL_FLAG];
        if (ctrl_wr) begin
            st_d.run = wdata[CTRL_RUN];
            st_d.ie  = wdata[CTRL_IE];
        end
        if (wr && (sel == SEL_PRESET)) begin
            st_d.preset = wdata;
        end
        run_nx   = st_d.run;
        ie_nx    = st_d.ie;
        run_q    = st_q.run;
        ie_q     = st_q.ie;
        preset_q = st_q.preset;
        rdata    = '0;
        if (sel == SEL_PRESET) begin
            rdata = st_q.preset;
        end else begin
            rdata[CTRL_RUN]  = st_q.run;
            rdata[CTRL_FLAG] = flag_i;
            rdata[CTRL_IE]   = st_q.ie;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/wkt_counter.sv
module wkt_counter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_q,
    input  logic             run_nx,
    input  logic [CNT_W-1:0] preset,
    input  logic             tick,
    output logic             evt
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        evt   = 1'b0;
        if (!(run_q && run_nx)) begin
            // halted, being stopped, or being started: sit on the preset
            cnt_d = preset;
        end else if (tick) begin
            if (cnt_q <= CNT_W'(1)) begin
                evt   = 1'b1;
                cnt_d = preset;
            end else begin
                cnt_d = cnt_q - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/wkt_irq.sv
module wkt_irq #(
    parameter int REL_TICKS = 1,
    localparam int REL_W    = $clog2(REL_TICKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic flag_clr,
    input  logic ie_nx,
    input  logic rel_tick,
    output logic flag_q,
    output logic irq_q
);
    typedef struct packed {
        logic             flag;
        logic             irq;
        logic [REL_W-1:0] rel;
    } irq_t;

    irq_t st_d, st_q;
    logic flag_pre;
    logic fresh;

    always_comb begin
        st_d     = st_q;
        flag_pre = flag_clr ? 1'b0 : st_q.flag;
        fresh    = evt && !flag_pre;
        st_d.flag = flag_pre || evt;
        if (!ie_nx) begin
            st_d.irq = 1'b0;
            st_d.rel = '0;
        end else if (fresh) begin
            st_d.irq = 1'b1;
            st_d.rel = REL_W'(REL_TICKS);
        end else if (st_q.irq && rel_tick) begin
            if (st_q.rel <= REL_W'(1)) begin
                st_d.irq = 1'b0;
                st_d.rel = '0;
            end else begin
                st_d.rel = st_q.rel - REL_W'(1);
            end
        end
        flag_q = st_q.flag;
        irq_q  = st_q.irq;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/wkt_top.sv
module wkt_top #(
    parameter int CNT_W     = 12,
    parameter int REL_TICKS = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_sel,
    input  logic [CNT_W-1:0] reg_wdata,
    output logic [CNT_W-1:0] reg_rdata,
    input  logic             src_tick,
    input  logic             rel_tick,
    output logic             flag_o,
    output logic             irq_o
);
    logic             run_q, run_nx, ie_q, ie_nx, flag_clr, tmr_evt;
    logic [CNT_W-1:0] preset_q;

    wkt_regs #(.CNT_W(CNT_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .sel(reg_sel), .wdata(reg_wdata),
        .flag_i(flag_o), .run_q(run_q), .run_nx(run_nx), .ie_q(ie_q), .ie_nx(ie_nx),
        .flag_clr(flag_clr), .preset_q(preset_q), .rdata(reg_rdata)
    );

    wkt_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .run_q(run_q), .run_nx(run_nx),
        .preset(preset_q), .tick(src_tick), .evt(tmr_evt)
    );

    wkt_irq #(.REL_TICKS(REL_TICKS)) irq_i (
        .clk(clk), .rst_n(rst_n), .evt(tmr_evt), .flag_clr(flag_clr), .ie_nx(ie_nx),
        .rel_tick(rel_tick), .flag_q(flag_o), .irq_q(irq_o)
    );
endmodule

// File: rtl/wkt_chk.sv
module wkt_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr,
    input logic       reg_sel,
    input logic [2:0] wr_bits,
    input logic       rel_tick,
    input logic       flag_o,
    input logic       irq_o,
    input logic       run_q,
    input logic       ie_q,
    input logic       evt
);
    logic ctrl_wr;
    assign ctrl_wr = reg_wr && !reg_sel;

    a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        flag_o && !(ctrl_wr && !wr_bits[1]) |=> flag_o);

    a_r9_clear_keeps_irq: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o && ctrl_wr && !wr_bits[1] && wr_bits[2] && !rel_tick |=> irq_o);

    a_r10_ie_off_releases: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr && !wr_bits[2] |=> !irq_o);

    a_r2_flag_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_o) |-> $past(run_q));

    a_r13_no_event_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
        evt |-> run_q && !(ctrl_wr && !wr_bits[0]));

    a_r7_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> ie_q && flag_o);
endmodule

bind wkt_top wkt_chk chk_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .wr_bits(reg_wdata[2:0]), .rel_tick(rel_tick), .flag_o(flag_o), .irq_o(irq_o),
    .run_q(run_q), .ie_q(ie_q), .evt(tmr_evt)
);

// File: tb/wkt_top_tb_top.sv
module wkt_top_tb_top;
    localparam int CW = 12;

    logic          clk = 1'b0;
    logic          rst_n, reg_wr, reg_sel, src_tick, rel_tick, flag_o, irq_o;
    logic [CW-1:0] reg_wdata, reg_rdata;
    int            checks = 0;
    int            fails  = 0;

    always #10 clk = ~clk;

    wkt_top #(.CNT_W(CW), .REL_TICKS(1)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_tick(src_tick),
        .rel_tick(rel_tick), .flag_o(flag_o), .irq_o(irq_o)
    );

    task automatic chk(string req, logic [CW-1:0] got, logic [CW-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    // one clock cycle, entered and left at a falling edge
    task automatic cyc(bit wr, bit sel, logic [CW-1:0] d, bit st, bit rt);
        reg_wr = wr; reg_sel = sel; reg_wdata = d; src_tick = st; rel_tick = rt;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0; src_tick = 1'b0; rel_tick = 1'b0;
    endtask

    task automatic ctrl(bit run, bit flg, bit ie);
        cyc(1'b1, 1'b0, CW'({ie, flg, run}), 1'b0, 1'b0);
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, '0, 1'b1, 1'b0);
    endtask

    task automatic count_to_flag(int lim, output int n);
        n = 0;
        while (!flag_o && n < lim) begin
            cyc(1'b0, 1'b0, '0, 1'b1, 1'b0);
            n++;
        end
    endtask

    task automatic rd(string req, bit sel, logic [CW-1:0] exp);
        reg_sel = sel;
        #2;
        chk(req, reg_rdata, exp);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        int n;
        int per;
        rst_n = 1'b0; reg_wr = 1'b0; reg_sel = 1'b0; reg_wdata = '0;
        src_tick = 1'b0; rel_tick = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 flag", CW'(flag_o), 0);
        chk("R1 irq", CW'(irq_o), 0);
        rd("R1 ctrl read", 1'b0, 0);
        rd("R1 preset read", 1'b1, 0);

        // R2 stopped: no events, writing 1 to flag ignored
        cyc(1'b1, 1'b1, 3, 1'b0, 1'b0);
        ctrl(1'b0, 1'b1, 1'b1);
        chk("R2 flag write-one ignored", CW'(flag_o), 0);
        ticks(20);
        chk("R2 no event while stopped", CW'(flag_o), 0);
        chk("R2 no irq while stopped", CW'(irq_o), 0);
        ctrl(1'b0, 1'b0, 1'b0);

        // R3 / R4 sweep over presets
        for (int p = 0; p <= 20; p++) begin
            per = (p == 0) ? 1 : p;
            cyc(1'b1, 1'b1, CW'(p), 1'b0, 1'b0);
            ctrl(1'b1, 1'b0, 1'b1);
            count_to_flag(40, n);
            chk($sformatf("R3 first period P=%0d", p), CW'(n), CW'(per));
            ctrl(1'b1, 1'b0, 1'b1);
            count_to_flag(40, n);
            chk($sformatf("R4 repeat period P=%0d", p), CW'(n), CW'(per));
            ctrl(1'b0, 1'b0, 1'b0);
        end

        // R5 / R7 with ie=0, preset 2
        cyc(1'b1, 1'b1, 2, 1'b0, 1'b0);
        ctrl(1'b1, 1'b0, 1'b0);
        count_to_flag(10, n);
        chk("R5 flag set by event", CW'(flag_o), 1);
        chk("R7 no irq with ie=0", CW'(irq_o), 0);
        ctrl(1'b1, 1'b1, 1'b0);
        chk("R5 write-one keeps flag", CW'(flag_o), 1);
        ctrl(1'b1, 1'b0, 1'b0);
        chk("R5 write-zero clears flag", CW'(flag_o), 0);
        ticks(1);
        cyc(1'b1, 1'b0, CW'(3'b111), 1'b1, 1'b0);
        chk("R7 ie set with event asserts irq", CW'(irq_o), 1);
        chk("R7 flag with event", CW'(flag_o), 1);

        // R9 / R11
        ctrl(1'b1, 1'b0, 1'b1);
        chk("R9 clear flag keeps irq", CW'(irq_o), 1);
        chk("R9 flag cleared", CW'(flag_o), 0);
        ticks(0);
        for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, '0, 1'b0, 1'b0);
        chk("R11 irq held without release tick", CW'(irq_o), 1);
        cyc(1'b0, 1'b0, '0, 1'b0, 1'b1);
        chk("R11 release tick drops irq", CW'(irq_o), 0);

        // R8
        ticks(2);
        chk("R8 fresh event irq", CW'(irq_o), 1);
        cyc(1'b0, 1'b0, '0, 1'b0, 1'b1);
        ticks(2);
        chk("R8 event with flag set no irq", CW'(irq_o), 0);
        chk("R8 flag still set", CW'(flag_o), 1);

        // R6 clear collides with event
        ticks(1);
        cyc(1'b1, 1'b0, CW'(3'b101), 1'b1, 1'b0);
        chk("R6 event wins over clear", CW'(flag_o), 1);
        chk("R6 irq asserted", CW'(irq_o), 1);

        // R10
        ctrl(1'b1, 1'b1, 1'b0);
        chk("R10 ie off releases irq", CW'(irq_o), 0);
        chk("R10 flag kept", CW'(flag_o), 1);

        // R11 release tick on the asserting cycle is not counted
        ctrl(1'b1, 1'b0, 1'b1);
        ticks(1);
        cyc(1'b0, 1'b0, '0, 1'b1, 1'b1);
        chk("R11 same-cycle release tick ignored", CW'(irq_o), 1);
        cyc(1'b0, 1'b0, '0, 1'b0, 1'b1);
        chk("R11 next release tick drops irq", CW'(irq_o), 0);

        // R13 / R3 restart after partial count
        ctrl(1'b0, 1'b0, 1'b0);
        cyc(1'b1, 1'b1, 6, 1'b0, 1'b0);
        ctrl(1'b1, 1'b0, 1'b1);
        ticks(4);
        cyc(1'b1, 1'b0, CW'(3'b100), 1'b1, 1'b0);
        chk("R13 stop with tick no event", CW'(flag_o), 0);
        ctrl(1'b1, 1'b0, 1'b1);
        count_to_flag(20, n);
        chk("R3 restart from preset", CW'(n), 6);

        // R13 stop on the expiring tick
        ctrl(1'b0, 1'b0, 1'b0);
        cyc(1'b1, 1'b1, 1, 1'b0, 1'b0);
        ctrl(1'b1, 1'b0, 1'b1);
        cyc(1'b1, 1'b0, CW'(3'b100), 1'b1, 1'b0);
        chk("R13 stop on expiring tick", CW'(flag_o), 0);

        // R12 preset change while running
        ctrl(1'b0, 1'b0, 1'b0);
        cyc(1'b1, 1'b1, 4, 1'b0, 1'b0);
        ctrl(1'b1, 1'b0, 1'b1);
        ticks(1);
        cyc(1'b1, 1'b1, 2, 1'b0, 1'b0);
        count_to_flag(20, n);
        chk("R12 running count unaffected", CW'(n), 3);
        ctrl(1'b1, 1'b0, 1'b1);
        count_to_flag(20, n);
        chk("R12 new preset at reload", CW'(n), 2);
        rd("R12 preset readback", 1'b1, 2);
        rd("R12 ctrl readback", 1'b0, 7);

        finish_run();
    end
endmodule